// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Monitor

This block tracks the reservation for word-wide load-reserved (LR) and store-conditional (SC) operations on a single in-order hart. The pipeline gives it one decoded request per cycle: the major opcode, the funct5 selector, the ordering bits, the effective address (rs1, with no offset) and the store data (rs2). The block drives a word memory port with a combinational read path. It returns the loaded word for LR. For SC it returns a status word, 0 for success and 1 for failure.

One reservation is held: a valid flag and a word address. LR sets it. SC tests it and then always clears it. The reservation is also dropped when the pipeline reports any plain store (at any address) or a trap entry. This is a conservative rule that suits a single hart. Only an SC that finds a valid reservation at the same word address writes memory.

Top module: `lrsc_monitor`

## Requirements
- R1: A request is accepted only when the opcode is 0101111 and funct5 is 00010 (LR) or 00011 (SC). Any other value gives no memory access, no response and no change to the reservation.
- R2: An aligned LR raises mem_req_o with mem_we_o low and mem_addr_o equal to the address in the request cycle. One cycle later it raises resp_valid_o with the word read from memory and resp_misalign_o low.
- R3: An aligned SC whose word address matches a valid reservation drives a memory write of the store data in the request cycle. One cycle later it returns 0.
- R4: Every accepted aligned SC clears the reservation, whether it passes or fails, so a second SC to the same address fails.
- R5: An SC with no valid reservation, or with a different word address, issues no memory write and returns 1 one cycle later.
- R6: plain_store_i clears the reservation. In the same cycle as an SC it makes that SC fail. In the same cycle as an LR it stops the reservation from being set, but the LR still returns its data.
- R7: trap_i clears the reservation. A request in the same cycle as trap_i makes no memory access, gives no response and sets no reservation.
- R8: The two ordering bits have no effect on any output or on the reservation.
- R9: An LR or SC whose address has bits [1:0] not equal to 0 makes no memory access. One cycle later it returns resp_valid_o with resp_misalign_o high and data 0, and the reservation is left unchanged.
- R10: During and after reset, resp_valid_o is low and no reservation is held, so the first SC fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Decoded request present |
| opcode_i | input | 7 | Major opcode of the request |
| funct5_i | input | 5 | Operation selector |
| order_i | input | 2 | Ordering bits (ignored) |
| addr_i | input | ADDR_W | Effective address (rs1) |
| wdata_i | input | DATA_W | Store data (rs2) |
| plain_store_i | input | 1 | Non-conditional store retiring this cycle |
| trap_i | input | 1 | Trap entry this cycle |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, same cycle |
| resp_valid_o | output | 1 | Result available |
| resp_data_o | output | DATA_W | Loaded word or SC status |
| resp_misalign_o | output | 1 | Result is a misaligned access |

## Verification
Two functions can fall in the same cycle: a reservation clear caused by a plain store or a trap, and an LR or SC request. The bench puts plain_store_i on the cycle of an SC and expects no write and a status of 1. It puts plain_store_i on the cycle of an LR and expects the data to come back while a following SC fails. It puts trap_i on the cycle of an LR and expects no response at all, followed by a failing SC to the previously reserved address. Each case is judged from mem_we_o in the request cycle and from the response one cycle later.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [4:0] F5_LR      = 5'b00010;
  localparam logic [4:0] F5_SC      = 5'b00011;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LR   = 2'd1,
    OP_SC   = 2'd2
  } lrsc_op_e;
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic              valid_i,
  input  logic [6:0]        opcode_i,
  input  logic [4:0]        funct5_i,
  input  logic [1:0]        order_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              trap_i,
  output lrsc_op_e          op_o,
  output logic              misalign_o
);
  logic unused_order;
  assign unused_order = ^order_i;

  always_comb begin
    op_o = OP_NONE;
    if (valid_i && !trap_i && opcode_i == OPC_ATOMIC) begin
      unique case (funct5_i)
        F5_LR:   op_o = OP_LR;
        F5_SC:   op_o = OP_SC;
        default: op_o = OP_NONE;
      endcase
    end
  end

  assign misalign_o = (op_o != OP_NONE) && (offset_i != '0);
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int TAG_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic [TAG_W-1:0] chk_tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             match_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      tag_q   <= set_tag_i;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign match_o = valid_q && (tag_q == chk_tag_i);

  p_set_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> (valid_o && tag_o == $past(set_tag_i)));
endmodule

// File: rtl/lrsc_resp.sv
module lrsc_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              mis_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic              mis_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mis_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= fire_i;
      mis_o   <= fire_i && mis_i;
      data_o  <= (fire_i && !mis_i) ? data_i : '0;
    end
  end

  p_resp_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(fire_i));
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [6:0]        opcode_i,
  input  logic [4:0]        funct5_i,
  input  logic [1:0]        order_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              plain_store_i,
  input  logic              trap_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              resp_misalign_o
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - OFF_W;

  lrsc_op_e         op;
  logic             mis;
  logic             lr_go, sc_go, sc_pass;
  logic             resv_valid, resv_match;
  logic [TAG_W-1:0] resv_tag;
  logic [DATA_W-1:0] result;

  lrsc_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_decode (
    .valid_i   (req_valid_i),
    .opcode_i  (opcode_i),
    .funct5_i  (funct5_i),
    .order_i   (order_i),
    .offset_i  (addr_i[OFF_W-1:0]),
    .trap_i    (trap_i),
    .op_o      (op),
    .misalign_o(mis)
  );

  assign lr_go   = (op == OP_LR) && !mis;
  assign sc_go   = (op == OP_SC) && !mis;
  assign sc_pass = sc_go && resv_match && !plain_store_i;

  lrsc_resv #(.TAG_W(TAG_W)) u_resv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (lr_go),
    .clr_i    (plain_store_i || trap_i || sc_go),
    .set_tag_i(addr_i[ADDR_W-1:OFF_W]),
    .chk_tag_i(addr_i[ADDR_W-1:OFF_W]),
    .valid_o  (resv_valid),
    .tag_o    (resv_tag),
    .match_o  (resv_match)
  );

  assign mem_req_o   = lr_go || sc_pass;
  assign mem_we_o    = sc_pass;
  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = wdata_i;

  assign result = lr_go ? mem_rdata_i : {{(DATA_W-1){1'b0}}, !sc_pass};

  lrsc_resp #(.DATA_W(DATA_W)) u_resp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (op != OP_NONE),
    .mis_i  (mis),
    .data_i (result),
    .valid_o(resp_valid_o),
    .mis_o  (resp_misalign_o),
    .data_o (resp_data_o)
  );

  p_req_only_atomic_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (opcode_i == OPC_ATOMIC && (funct5_i == F5_LR || funct5_i == F5_SC)));
  p_read_answers_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (resp_valid_o && !resp_misalign_o));
  p_write_needs_resv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (resv_valid && resv_tag == addr_i[ADDR_W-1:OFF_W]));
  p_sc_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_go |=> !resv_valid);
  p_fail_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_go && !mem_we_o) |=> (resp_data_o == DATA_W'(1)));
  p_store_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_store_i |=> !resv_valid);
  p_trap_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (!resv_valid && !resp_valid_o));
  p_misalign_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_NONE && mis) |-> (!mem_req_o ##1 (resp_misalign_o && resp_data_o == '0)));
endmodule

// File: tb/lrsc_monitor_bench.sv
`timescale 1ns/1ps
module lrsc_monitor_bench;
  localparam logic [6:0] ATOM = 7'b0101111;
  localparam logic [6:0] LOAD = 7'b0000011;
  localparam logic [4:0] LR = 5'b00010, SC = 5'b00011, SWAP = 5'b00001;

  typedef struct packed {
    logic [3:0]  req;
    logic [6:0]  opc;
    logic [4:0]  f5;
    logic [1:0]  ord;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic        ps;
    logic        tr;
    logic        rv;
    logic [31:0] data;
    logic        mis;
    logic        we;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd10, ATOM, SC,   2'd0, 8'h08, 32'h55, 1'b0, 1'b0, 1'b1, 32'h1,        1'b0, 1'b0}, // R10 no resv after reset
    '{4'd2,  ATOM, LR,   2'd0, 8'h08, 32'h0,  1'b0, 1'b0, 1'b1, 32'h10000002, 1'b0, 1'b0}, // R2
    '{4'd3,  ATOM, SC,   2'd0, 8'h08, 32'hAA, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 1'b1}, // R3
    '{4'd4,  ATOM, SC,   2'd0, 8'h08, 32'hBB, 1'b0, 1'b0, 1'b1, 32'h1,        1'b0, 1'b0}, // R4
    '{4'd3,  ATOM, LR,   2'd0, 8'h08, 32'h0,  1'b0, 1'b0, 1'b1, 32'hAA,       1'b0, 1'b0}, // R3 write landed
    '{4'd5,  ATOM, SC,   2'd0, 8'h0C, 32'hCC, 1'b0, 1'b0, 1'b1, 32'h1,        1'b0, 1'b0}, // R5 mismatch
    '{4'd8,  ATOM, LR,   2'd3, 8'h10, 32'h0,  1'b0, 1'b0, 1'b1, 32'h10000004, 1'b0, 1'b0}, // R8
    '{4'd6,  7'd0, 5'd0, 2'd0, 8'h00, 32'h0,  1'b1, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0}, // R6 plain store
    '{4'd6,  ATOM, SC,   2'd0, 8'h10, 32'hDD, 1'b0, 1'b0, 1'b1, 32'h1,        1'b0, 1'b0}, // R6
    '{4'd8,  ATOM, LR,   2'd2, 8'h10, 32'h0,  1'b0, 1'b0, 1'b1, 32'h10000004, 1'b0, 1'b0}, // R8
    '{4'd7,  7'd0, 5'd0, 2'd0, 8'h00, 32'h0,  1'b0, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0}, // R7 trap
    '{4'd7,  ATOM, SC,   2'd0, 8'h10, 32'hDD, 1'b0, 1'b0, 1'b1, 32'h1,        1'b0, 1'b0}, // R7
    '{4'd2,  ATOM, LR,   2'd0, 8'h14, 32'h0,  1'b0, 1'b0, 1'b1, 32'h10000005, 1'b0, 1'b0}, // R2
    '{4'd1,  ATOM, SWAP, 2'd0, 8'h14, 32'h9,  1'b0, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0}, // R1 other funct5
    '{4'd1,  LOAD, SC,   2'd0, 8'h14, 32'h9,  1'b0, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0}, // R1 other opcode
    '{4'd1,  ATOM, SC,   2'd1, 8'h14, 32'hEE, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 1'b1}, // R1 R8 resv kept
    '{4'd9,  ATOM, LR,   2'd0, 8'h16, 32'h0,  1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 1'b0}, // R9
    '{4'd2,  ATOM, LR,   2'd0, 8'h18, 32'h0,  1'b0, 1'b0, 1'b1, 32'h10000006, 1'b0, 1'b0}, // R2
    '{4'd9,  ATOM, SC,   2'd0, 8'h1A, 32'h66, 1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 1'b0}, // R9
    '{4'd9,  ATOM, SC,   2'd0, 8'h18, 32'h77, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 1'b1}, // R9 resv unchanged
    '{4'd3,  ATOM, LR,   2'd0, 8'h18, 32'h0,  1'b0, 1'b0, 1'b1, 32'h77,       1'b0, 1'b0}, // R3
    '{4'd6,  ATOM, LR,   2'd0, 8'h1C, 32'h0,  1'b1, 1'b0, 1'b1, 32'h10000007, 1'b0, 1'b0}, // R6 LR with store
    '{4'd6,  ATOM, SC,   2'd0, 8'h1C, 32'h12, 1'b0, 1'b0, 1'b1, 32'h1,        1'b0, 1'b0}, // R6
    '{4'd2,  ATOM, LR,   2'd0, 8'h20, 32'h0,  1'b0, 1'b0, 1'b1, 32'h10000008, 1'b0, 1'b0}, // R2
    '{4'd6,  ATOM, SC,   2'd0, 8'h20, 32'h34, 1'b1, 1'b0, 1'b1, 32'h1,        1'b0, 1'b0}, // R6 SC with store
    '{4'd2,  ATOM, LR,   2'd0, 8'h24, 32'h0,  1'b0, 1'b0, 1'b1, 32'h10000009, 1'b0, 1'b0}, // R2
    '{4'd7,  ATOM, LR,   2'd0, 8'h28, 32'h0,  1'b0, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0}, // R7 LR with trap
    '{4'd7,  ATOM, SC,   2'd0, 8'h24, 32'h56, 1'b0, 1'b0, 1'b1, 32'h1,        1'b0, 1'b0}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [6:0]  opcode = '0;
  logic [4:0]  funct5 = '0;
  logic [1:0]  order = '0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        pstore = 1'b0;
  logic        trap = 1'b0;
  logic        mem_req_o, mem_we_o, resp_valid_o, resp_misalign_o;
  logic [31:0] mem_addr_o, mem_wdata_o, resp_data_o, mem_rdata;
  logic [31:0] mem [16];
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr_o[5:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h10000000 | 32'(i);
    end else if (mem_req_o && mem_we_o) begin
      mem[mem_addr_o[5:2]] <= mem_wdata_o;
    end
  end

  lrsc_monitor u_lrsc_monitor (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .opcode_i(opcode),
    .funct5_i(funct5), .order_i(order), .addr_i(addr), .wdata_i(wdata),
    .plain_store_i(pstore), .trap_i(trap), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata), .resp_valid_o(resp_valid_o),
    .resp_data_o(resp_data_o), .resp_misalign_o(resp_misalign_o)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = (v.opc != 7'd0);
    opcode = v.opc; funct5 = v.f5; order = v.ord;
    addr = {24'd0, v.addr}; wdata = v.wd; pstore = v.ps; trap = v.tr;
  endtask

  task automatic idle();
    req_valid = 1'b0; opcode = '0; funct5 = '0; order = '0;
    addr = '0; wdata = '0; pstore = 1'b0; trap = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    @(negedge clk);
    drive(v);
    #1;
    chk($sformatf("R%0d vec%0d mem_we", v.req, idx), 32'(mem_we_o), 32'(v.we));
    @(posedge clk);
    #1;
    chk($sformatf("R%0d vec%0d resp_valid", v.req, idx), 32'(resp_valid_o), 32'(v.rv));
    if (v.rv) begin
      chk($sformatf("R%0d vec%0d data", v.req, idx), resp_data_o, v.data);
      chk($sformatf("R%0d vec%0d misalign", v.req, idx), 32'(resp_misalign_o), 32'(v.mis));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 resp_valid in reset", 32'(resp_valid_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 resp_valid after reset", 32'(resp_valid_o), 32'h0);
    chk("R10 mem_req idle", 32'(mem_req_o), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    @(negedge clk); idle();

    // R10: reset in the middle drops a live reservation
    run_vec('{4'd10, ATOM, LR, 2'd0, 8'h0C, 32'h0, 1'b0, 1'b0, 1'b1, 32'h10000003, 1'b0, 1'b0}, 100);
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 resp_valid held low in reset", 32'(resp_valid_o), 32'h0);
    rst_n = 1'b1;
    run_vec('{4'd10, ATOM, SC, 2'd0, 8'h0C, 32'h99, 1'b0, 1'b0, 1'b1, 32'h1, 1'b0, 1'b0}, 101);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R5 memory untouched by failed SC", mem[3], 32'h10000003);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule